// File: doc/BRIEF.md
# Sleep-Aware Converter Run Controller

This block sits beside a data converter and decides, cycle by cycle, whether the converter may hold its clock, power its analog front end and start conversions. It bases that decision on the system power mode and three configuration bits: an enable, a keep-running-in-sleep bit and an on-demand bit. In the shallow sleep modes the converter can be kept running continuously. It can also be parked with its front end unpowered and woken only when an event source asks for a conversion. In the deep modes it is always held quiet.

A request for the converter first raises a clock request. Once the clock is granted, the front end is powered and a settling counter runs for `SETTLE_CYC` cycles before the ready flag rises. A pending start request then produces a one-cycle start strobe on the following cycle. In on-demand operation, the conversion-done pulse powers everything back down. Start requests that arrive while the block is busy are held and serviced once.

Top module: `periph_run_ctrl`

## Requirements
- R1: While `cfg_en` is 0, every output stays 0 in every power mode, and a start request seen while disabled is discarded, so enabling afterwards starts nothing.
- R2: Out of reset all outputs are 0. In Active mode (`pwr_mode` = 0) with `cfg_en` = 1, the block raises `clk_req` and reaches a steady `afe_ready` = 1 with no start request, whatever the other two bits are.
- R3: In Idle (1) or Standby (2) with run-in-sleep = 0 and on-demand = 0, the block is inactive. A start request produces neither `wake_req` nor `clk_req`, and it is not remembered when on-demand is set later.
- R4: In Idle or Standby with run-in-sleep = 1 and on-demand = 0, `clk_req` and `afe_ready` stay high with no start request. After a conversion ends, `afe_ready` remains high.
- R5: In Idle or Standby with on-demand = 1 (either run-in-sleep value), `clk_req` and `afe_pwr` stay 0 until a start request. A start request raises `wake_req` combinationally in the same cycle, and `clk_req` follows.
- R6: `afe_pwr` stays 0 and `afe_ready` stays 0 while `clk_grant` is withheld. After `clk_grant` is sampled high, `afe_ready` rises after exactly `SETTLE_CYC`+1 rising edges.
- R7: `conv_start` is a single-cycle pulse. It is issued one cycle after `afe_ready` is high with a request pending, never in the cycle `afe_ready` first rises.
- R8: In on-demand operation, a `conv_done` pulse causes `clk_req`, `afe_pwr` and `afe_ready` to be 0 in the next cycle.
- R9: Start requests arriving during settling or a conversion are latched, and each latched group produces exactly one further `conv_start`.
- R10: In Hibernate (3), Backup (4), Off (5) and the unused codes 6 and 7, every output is 0 in the same cycle the mode is applied.
- R11: `afe_ready` is only ever high while both `afe_pwr` and `clk_req` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_mode | input | 3 | System power mode: 0 Active, 1 Idle, 2 Standby, 3 Hibernate, 4 Backup, 5 Off |
| cfg_en | input | 1 | Converter enable |
| cfg_run_sleep | input | 1 | Keep the converter running in Idle and Standby |
| cfg_on_demand | input | 1 | Power up only when a start request arrives |
| evt_start | input | 1 | Conversion start request from the event source |
| clk_grant | input | 1 | Clock granted in answer to `clk_req` |
| conv_done | input | 1 | Conversion complete pulse |
| clk_req | output | 1 | Clock request to the clock controller |
| afe_pwr | output | 1 | Analog front end power enable |
| afe_ready | output | 1 | Front end settled and usable |
| conv_start | output | 1 | One-cycle conversion start strobe |
| wake_req | output | 1 | Wake request to the system on an on-demand start |

## Verification
The hardest case to reach from the ports is a second start request landing while the first conversion is still running in on-demand mode. It must survive the power-down caused by `conv_done` and then drive a full new power-up, settle and strobe sequence exactly once. The bench reaches it by waiting for the first strobe, then pulsing `evt_start` on two back-to-back cycles before `conv_done`, and counting strobes over long windows afterwards. Withheld clock grants are produced by gating the bench's grant loopback, which holds the block in its request state.

// File: rtl/prc_pkg.sv
// Shared definitions for the converter run controller.
// Assumes a 3-bit power mode code; codes above Off are treated as deep modes.
package prc_pkg;

    localparam logic [2:0] PM_ACTIVE    = 3'd0;
    localparam logic [2:0] PM_IDLE      = 3'd1;
    localparam logic [2:0] PM_STANDBY   = 3'd2;
    localparam logic [2:0] PM_HIBERNATE = 3'd3;
    localparam logic [2:0] PM_BACKUP    = 3'd4;
    localparam logic [2:0] PM_OFF       = 3'd5;

    // Sequencer states: clock off, waiting for grant, settling, ready, converting
    typedef enum logic [2:0] {
        SQ_OFF    = 3'd0,
        SQ_REQ    = 3'd1,
        SQ_SETTLE = 3'd2,
        SQ_READY  = 3'd3,
        SQ_CONV   = 3'd4
    } seq_state_e;

    // Run decision derived from power mode and configuration
    typedef struct packed {
        logic allowed;    // converter may be active at all
        logic always_on;  // keep clock and front end up without a request
        logic on_demand;  // power up only on a start request
    } run_policy_t;

endpackage

// File: rtl/prc_policy.sv
// Run policy decoder.
// Maps power mode plus enable / run-in-sleep / on-demand bits onto a run policy.
// Purely combinational; assumes inputs are synchronous to the block clock.
module prc_policy
    import prc_pkg::*;
(
    input  logic [2:0]  pwr_mode,
    input  logic        cfg_en,
    input  logic        cfg_run_sleep,
    input  logic        cfg_on_demand,
    output run_policy_t pol
);

    logic mode_active;
    logic mode_sleep;

    // Classify the power mode into active, shallow sleep, or deep (neither)
    always_comb begin
        mode_active = (pwr_mode == PM_ACTIVE);
        mode_sleep  = (pwr_mode == PM_IDLE) || (pwr_mode == PM_STANDBY);
    end

    // Build the run policy from the mode class and the configuration bits
    always_comb begin
        pol.always_on = cfg_en && (mode_active ||
                        (mode_sleep && cfg_run_sleep && !cfg_on_demand));
        pol.on_demand = cfg_en && mode_sleep && cfg_on_demand;
        pol.allowed   = pol.always_on || pol.on_demand;
    end

endmodule

// File: rtl/prc_pending.sv
// Start request latch.
// Holds one pending conversion request until the sequencer takes it.
// A new request in the same cycle as a take keeps the latch set.
// Requests seen while the converter is not allowed to run are discarded.
module prc_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic allowed,
    input  logic start_in,
    input  logic take,
    output logic pend
);

    // Set on an accepted request, clear on take or when running is forbidden
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (!allowed)
            pend <= 1'b0;
        else
            pend <= start_in || (pend && !take);
    end

    // R9
    pend_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_in && allowed) |=> pend);

    // R1
    pend_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!allowed) |=> !pend);

endmodule

// File: rtl/prc_settle.sv
// Front end settling timer.
// Loaded when the clock grant is seen, then counts down while running.
// Assumes SETTLE_CYC >= 1; the settling phase then lasts SETTLE_CYC cycles.
module prc_settle #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    // Down-counter: load on grant, decrement while settling, rest at zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= LOAD_VAL;
        else if (run && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    // Settling is over once the count has reached zero
    always_comb expired = (cnt == '0);

    // R6
    settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD_VAL);

endmodule

// File: rtl/prc_seq.sv
// Run sequencer.
// Walks clock request, grant wait, front end settling, ready and conversion.
// Always-on policy parks in READY; on-demand policy returns to OFF after a
// conversion. Loss of permission forces OFF from any state.
module prc_seq
    import prc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic allowed,
    input  logic always_on,
    input  logic pend,
    input  logic clk_grant,
    input  logic conv_done,
    input  logic expired,
    output logic take,
    output logic load,
    output logic run,
    output logic clk_req_raw,
    output logic afe_pwr_raw,
    output logic ready_raw,
    output logic strobe
);

    seq_state_e st;
    seq_state_e st_n;

    // Next-state and settle-timer control
    always_comb begin
        st_n = st;
        load = 1'b0;
        if (!allowed) begin
            st_n = SQ_OFF;
        end else begin
            case (st)
                SQ_OFF:    if (always_on || pend) st_n = SQ_REQ;
                SQ_REQ:    if (clk_grant) begin
                               st_n = SQ_SETTLE;
                               load = 1'b1;
                           end
                SQ_SETTLE: if (expired) st_n = SQ_READY;
                SQ_READY:  if (pend) st_n = SQ_CONV;
                           else if (!always_on) st_n = SQ_OFF;
                SQ_CONV:   if (conv_done) st_n = always_on ? SQ_READY : SQ_OFF;
                default:   st_n = SQ_OFF;
            endcase
        end
    end

    // Request handover and settle timer enable
    always_comb begin
        take = (st == SQ_READY) && pend && allowed;
        run  = (st == SQ_SETTLE);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_OFF;
        else        st <= st_n;
    end

    // Start strobe, issued the cycle after a request is taken in READY
    always_ff @(posedge clk) begin
        if (!rst_n) strobe <= 1'b0;
        else        strobe <= take;
    end

    // Raw outputs decoded from the state
    always_comb begin
        clk_req_raw = (st != SQ_OFF);
        afe_pwr_raw = (st == SQ_SETTLE) || (st == SQ_READY) || (st == SQ_CONV);
        ready_raw   = (st == SQ_READY) || (st == SQ_CONV);
    end

    // R6
    ready_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_raw) |-> ($past(st) == SQ_SETTLE) && $past(expired));

    // R8
    demand_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_CONV && conv_done && allowed && !always_on) |=> (st == SQ_OFF));

    // R6
    grant_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_REQ && !clk_grant && allowed) |=> (st == SQ_REQ));

endmodule

// File: rtl/periph_run_ctrl.sv
// Sleep-aware converter run controller (top).
// Combines the policy decoder, request latch, settle timer and sequencer.
// All outputs are gated by the current policy so that deep modes and a
// cleared enable silence the block in the same cycle they are applied.
module periph_run_ctrl
    import prc_pkg::*;
#(
    parameter int SETTLE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] pwr_mode,
    input  logic       cfg_en,
    input  logic       cfg_run_sleep,
    input  logic       cfg_on_demand,
    input  logic       evt_start,
    input  logic       clk_grant,
    input  logic       conv_done,
    output logic       clk_req,
    output logic       afe_pwr,
    output logic       afe_ready,
    output logic       conv_start,
    output logic       wake_req
);

    run_policy_t pol;
    logic pend, take, load, run, expired;
    logic clk_req_raw, afe_pwr_raw, ready_raw, strobe;

    prc_policy u_policy (
        .pwr_mode      (pwr_mode),
        .cfg_en        (cfg_en),
        .cfg_run_sleep (cfg_run_sleep),
        .cfg_on_demand (cfg_on_demand),
        .pol           (pol)
    );

    prc_pending u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .allowed  (pol.allowed),
        .start_in (evt_start),
        .take     (take),
        .pend     (pend)
    );

    prc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .run     (run),
        .expired (expired)
    );

    prc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .allowed     (pol.allowed),
        .always_on   (pol.always_on),
        .pend        (pend),
        .clk_grant   (clk_grant),
        .conv_done   (conv_done),
        .expired     (expired),
        .take        (take),
        .load        (load),
        .run         (run),
        .clk_req_raw (clk_req_raw),
        .afe_pwr_raw (afe_pwr_raw),
        .ready_raw   (ready_raw),
        .strobe      (strobe)
    );

    // Gate every output with the present run permission
    always_comb begin
        clk_req    = clk_req_raw && pol.allowed;
        afe_pwr    = afe_pwr_raw && pol.allowed;
        afe_ready  = ready_raw   && pol.allowed;
        conv_start = strobe      && pol.allowed;
        wake_req   = evt_start   && pol.on_demand;
    end

    // R10
    deep_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode > PM_STANDBY) |->
            !(clk_req || afe_pwr || afe_ready || conv_start || wake_req));

    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !(clk_req || afe_pwr || afe_ready || conv_start || wake_req));

    // R11
    ready_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        afe_ready |-> (afe_pwr && clk_req));

    // R7
    strobe_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(afe_ready));

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R5
    wake_sleep_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ((pwr_mode == PM_IDLE || pwr_mode == PM_STANDBY) && cfg_on_demand));

endmodule

// File: tb/sim_periph_run_ctrl.sv
module sim_periph_run_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 5;
    localparam int NVEC       = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pwr_mode = 3'd0;
    logic       cfg_en = 1'b0, cfg_run_sleep = 1'b0, cfg_on_demand = 1'b0;
    logic       evt_start = 1'b0, conv_done = 1'b0, grant_en = 1'b1;
    logic       clk_grant;
    logic       clk_req, afe_pwr, afe_ready, conv_start, wake_req;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Clock controller model: grants whenever asked, unless withheld
    assign clk_grant = grant_en && clk_req;

    periph_run_ctrl #(.SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode),
        .cfg_en(cfg_en), .cfg_run_sleep(cfg_run_sleep), .cfg_on_demand(cfg_on_demand),
        .evt_start(evt_start), .clk_grant(clk_grant), .conv_done(conv_done),
        .clk_req(clk_req), .afe_pwr(afe_pwr), .afe_ready(afe_ready),
        .conv_start(conv_start), .wake_req(wake_req)
    );

    // Policy vectors: {mode[2:0], en, run_sleep, on_demand, exp clk_req, exp ready}
    localparam logic [7:0] VEC [NVEC] = '{
        {3'd0, 3'b100, 2'b11},  // R2 active, plain enable
        {3'd0, 3'b101, 2'b11},  // R2 active, on-demand bit ignored
        {3'd0, 3'b011, 2'b00},  // R1 active, disabled
        {3'd1, 3'b100, 2'b00},  // R3 idle, neither bit
        {3'd1, 3'b110, 2'b11},  // R4 idle, run in sleep
        {3'd1, 3'b101, 2'b00},  // R5 idle, on demand, no request
        {3'd2, 3'b111, 2'b00},  // R5 standby, both bits, no request
        {3'd2, 3'b110, 2'b11},  // R4 standby, run in sleep
        {3'd2, 3'b010, 2'b00},  // R1 standby, disabled
        {3'd3, 3'b110, 2'b00},  // R10 hibernate
        {3'd4, 3'b110, 2'b00},  // R10 backup
        {3'd5, 3'b110, 2'b00}   // R10 off
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cfg(input logic [2:0] m, input logic e, input logic r, input logic o);
        pwr_mode = m; cfg_en = e; cfg_run_sleep = r; cfg_on_demand = o;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog all requirements: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        int strobes;
        cfg(3'd0, 1'b1, 1'b0, 1'b0);
        repeat (3) step();
        // R2 reset state
        chk("R2", "clk_req in reset", clk_req, 1'b0);
        chk("R2", "afe_pwr in reset", afe_pwr, 1'b0);
        chk("R2", "afe_ready in reset", afe_ready, 1'b0);
        chk("R2", "conv_start in reset", conv_start, 1'b0);
        rst_n = 1'b1;

        // Policy table walk
        for (int i = 0; i < NVEC; i++) begin
            cfg(VEC[i][7:5], VEC[i][4], VEC[i][3], VEC[i][2]);
            repeat (14) step();
            chk($sformatf("vec%0d", i), "clk_req", clk_req, VEC[i][1]);
            chk($sformatf("vec%0d", i), "afe_ready", afe_ready, VEC[i][0]);
        end

        // R5 / R6 / R7 / R8: on-demand request with grant withheld
        cfg(3'd1, 1'b1, 1'b0, 1'b1);
        grant_en = 1'b0;
        repeat (3) step();
        chk("R5", "afe_pwr idle on-demand", afe_pwr, 1'b0);
        evt_start = 1'b1; #1;
        chk("R5", "wake_req on start", wake_req, 1'b1);
        step(); evt_start = 1'b0;
        step();
        chk("R5", "clk_req after start", clk_req, 1'b1);
        chk("R6", "afe_pwr before grant", afe_pwr, 1'b0);
        repeat (5) step();
        chk("R6", "afe_ready grant withheld", afe_ready, 1'b0);
        chk("R6", "afe_pwr grant withheld", afe_pwr, 1'b0);
        grant_en = 1'b1;
        n = 0;
        do begin step(); n++; end while (!afe_ready && n < 50);
        chk_int("R6", "edges grant to ready", n, SETTLE + 1);
        chk("R11", "afe_pwr with ready", afe_pwr, 1'b1);
        chk("R11", "clk_req with ready", clk_req, 1'b1);
        chk("R7", "no strobe as ready rises", conv_start, 1'b0);
        step();
        chk("R7", "strobe one cycle later", conv_start, 1'b1);
        step();
        chk("R7", "strobe single cycle", conv_start, 1'b0);
        conv_done = 1'b1; step(); conv_done = 1'b0;
        chk("R8", "clk_req after done", clk_req, 1'b0);
        chk("R8", "afe_pwr after done", afe_pwr, 1'b0);
        chk("R8", "afe_ready after done", afe_ready, 1'b0);
        repeat (5) step();
        chk("R8", "stays off", clk_req, 1'b0);

        // R9: requests during a conversion serviced exactly once
        cfg(3'd2, 1'b1, 1'b1, 1'b1);
        evt_start = 1'b1; step(); evt_start = 1'b0;
        n = 0;
        while (!conv_start && n < 40) begin step(); n++; end
        chk("R9", "first strobe seen", conv_start, 1'b1);
        evt_start = 1'b1; step(); step(); evt_start = 1'b0;
        conv_done = 1'b1; step(); conv_done = 1'b0;
        strobes = 0;
        for (int k = 0; k < 40; k++) begin
            if (conv_start) strobes++;
            step();
        end
        chk_int("R9", "strobes for latched pair", strobes, 1);
        conv_done = 1'b1; step(); conv_done = 1'b0;
        strobes = 0;
        for (int k = 0; k < 30; k++) begin
            if (conv_start) strobes++;
            step();
        end
        chk_int("R9", "no extra strobe", strobes, 0);
        chk("R9", "clk_req idle after service", clk_req, 1'b0);

        // R1: request while disabled is discarded
        cfg(3'd1, 1'b0, 1'b0, 1'b1);
        step();
        evt_start = 1'b1; #1;
        chk("R1", "wake_req disabled", wake_req, 1'b0);
        step(); evt_start = 1'b0;
        cfg_en = 1'b1;
        repeat (10) step();
        chk("R1", "no start after enable", clk_req, 1'b0);

        // R3: inactive policy ignores and forgets requests
        cfg(3'd2, 1'b1, 1'b0, 1'b0);
        step();
        evt_start = 1'b1; #1;
        chk("R3", "wake_req inactive", wake_req, 1'b0);
        step(); evt_start = 1'b0;
        repeat (10) step();
        chk("R3", "clk_req inactive", clk_req, 1'b0);
        cfg_on_demand = 1'b1;
        repeat (10) step();
        chk("R3", "request not remembered", clk_req, 1'b0);

        // R4: run-in-sleep keeps ready through a conversion
        cfg(3'd2, 1'b1, 1'b1, 1'b0);
        repeat (14) step();
        chk("R4", "ready standby", afe_ready, 1'b1);
        evt_start = 1'b1; step(); evt_start = 1'b0;
        step();
        chk("R4", "strobe in run-in-sleep", conv_start, 1'b1);
        conv_done = 1'b1; step(); conv_done = 1'b0;
        chk("R4", "ready held after done", afe_ready, 1'b1);
        chk("R4", "clk_req held after done", clk_req, 1'b1);

        // R10: deep modes silence outputs immediately
        pwr_mode = 3'd4; #1;
        chk("R10", "clk_req backup", clk_req, 1'b0);
        chk("R10", "afe_pwr backup", afe_pwr, 1'b0);
        chk("R10", "afe_ready backup", afe_ready, 1'b0);
        evt_start = 1'b1; #1;
        chk("R10", "wake_req backup", wake_req, 1'b0);
        step(); evt_start = 1'b0;
        pwr_mode = 3'd7; step();
        chk("R10", "clk_req code 7", clk_req, 1'b0);
        pwr_mode = 3'd0;
        repeat (14) step();
        chk("R2", "ready back in active", afe_ready, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule